// File: doc/BRIEF.md
# Shared-Bus Rotating-Priority Arbiter

This block decides which agent drives a shared external bus. The agents are a set of peer processors, eight by default, and one host. Each peer raises a request line and receives a one-hot grant. The host has its own request, grant and a preempt line. Between peers, ownership rotates: the peer that last held the bus drops to the lowest priority. An owner keeps the bus for as long as it keeps requesting. A hold timer forces a peer off the bus after a set number of cycles while other agents are waiting. A lock line from the owner switches the timer off, so that a read-modify-write sequence completes without interruption.

The host can use its preempt line at any time to force a peer owner off the bus. The host then takes the bus and keeps it until it drops its request. Every change of owner passes through one cycle in which no grant is active. The control pins are plain level signals. There is no data path, so no valid/ready handshake applies.

Top module: `bus_arbiter`

## Requirements
- R1: During and right after reset, no grant is active (`peer_grant` = 0, `host_grant` = 0, `owner_id` = 0), and peer 0 holds the highest rotating priority.
- R2: At most one of `host_grant` and the bits of `peer_grant` is high in any cycle.
- R3: When no grant is active at a clock edge, a pending `host_req` wins that edge. Otherwise the requesting peer closest after the last peer owner, in ascending index order with wrap-around, is granted at that edge.
- R4: A peer owner keeps its grant while it requests and is not forced off. When it drops its request, its grant falls at the next edge. Every change of owner includes at least one cycle with no grant.
- R5: A peer that has held its grant for FAIR_LIMIT cycles is forced off at the next edge if another peer or the host is requesting and `lock` is low.
- R6: While `lock` is high, the hold timer has no effect: the owner keeps its grant for as long as it requests and `host_backoff` stays low.
- R7: `host_backoff` high while a peer owns the bus removes that grant at the next edge, regardless of `lock` or the timer. If `host_req` is high, `host_grant` rises one edge later.
- R8: Once granted, the host keeps `host_grant` until `host_req` goes low, whatever the peers, `lock` or `host_backoff` do. Its grant falls at the next edge after `host_req` goes low.
- R9: `owner_id` shows the binary index of the granted peer, and 0 when no peer holds a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| peer_req | input | N_PEERS | Bus request, one bit per peer |
| lock | input | 1 | Owner holds the bus for an indivisible sequence |
| host_req | input | 1 | Host bus request |
| host_backoff | input | 1 | Host forces the current peer owner off |
| peer_grant | output | N_PEERS | One-hot peer grant |
| host_grant | output | 1 | Host owns the bus |
| owner_id | output | IDW | Index of the granted peer |

## Verification
The bench builds the arbiter with four peers and a hold limit of five cycles. With these values the pointer wraps around often, and forced hand-offs happen many times in each run, so contention, lock and host preemption all overlap with the timer expiry within a few thousand cycles. A cycle model in the bench tracks the owner, the rotation pointer and the hold count. A per-peer wait counter checks that no peer waits longer than the bound set by the rotation and the hold limit.

// File: rtl/arb_pkg.sv
package arb_pkg;
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N   = 8,
  parameter int IDW = 3
) (
  input  logic [N-1:0]   req,
  input  logic [IDW-1:0] last,
  output logic           found,
  output logic [IDW-1:0] idx
);
  // scan from last+N down to last+1; the final hit is the nearest after last
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = N; k >= 1; k--) begin
      int pos;
      pos = (int'(last) + k) % N;
      if (req[pos]) begin
        found = 1'b1;
        idx   = IDW'(pos);
      end
    end
  end
endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expired
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (clear)                cnt_q <= '0;
    else if (run && cnt_q != TOP)  cnt_q <= cnt_q + 1'b1;
  end

  assign expired = (cnt_q == TOP);

  // R5
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && run && !clear) |=> expired);
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
  import arb_pkg::*;
#(
  parameter int N_PEERS    = 8,
  parameter int FAIR_LIMIT = 16,
  localparam int IDW       = idx_width(N_PEERS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_PEERS-1:0] peer_req,
  input  logic               lock,
  input  logic               host_req,
  input  logic               host_backoff,
  output logic [N_PEERS-1:0] peer_grant,
  output logic               host_grant,
  output logic [IDW-1:0]     owner_id
);
  logic [N_PEERS-1:0] gnt_q;
  logic               host_q;
  logic [IDW-1:0]     own_q, last_q;
  logic               peer_busy, own_req, contend, release_now;
  logic               pk_found, grant_new, expired;
  logic [IDW-1:0]     pk_idx;

  rr_pick #(.N(N_PEERS), .IDW(IDW)) u_pick (
    .req(peer_req), .last(last_q), .found(pk_found), .idx(pk_idx)
  );

  assign peer_busy   = |gnt_q;
  assign own_req     = peer_req[own_q];
  assign contend     = (|(peer_req & ~gnt_q)) | host_req;
  assign release_now = peer_busy &&
                       (!own_req || host_backoff || (expired && !lock && contend));
  assign grant_new   = !peer_busy && !host_q && !host_req && pk_found;

  hold_timer #(.LIMIT(FAIR_LIMIT)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .clear(grant_new), .run(peer_busy && !release_now),
    .expired(expired)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_q  <= '0;
      host_q <= 1'b0;
      own_q  <= '0;
      last_q <= IDW'(N_PEERS - 1);
    end else if (host_q) begin
      if (!host_req) host_q <= 1'b0;
    end else if (peer_busy) begin
      if (release_now) begin
        gnt_q  <= '0;
        last_q <= own_q;
      end
    end else if (host_req) begin
      host_q <= 1'b1;
    end else if (pk_found) begin
      gnt_q         <= '0;
      gnt_q[pk_idx] <= 1'b1;
      own_q         <= pk_idx;
    end
  end

  assign peer_grant = gnt_q;
  assign host_grant = host_q;
  assign owner_id   = peer_busy ? own_q : '0;

  // R2
  one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({host_grant, peer_grant}));

  // R4
  idle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_grant || |peer_grant) |=>
      (({host_grant, peer_grant} == $past({host_grant, peer_grant})) ||
       ({host_grant, peer_grant} == '0)));

  // R6
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(peer_grant & peer_req)) && lock && !host_backoff) |=>
      (peer_grant == $past(peer_grant)));

  // R7
  backoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|peer_grant) && host_backoff) |=> (peer_grant == '0));

  // R8
  host_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_grant && host_req) |=> host_grant);
endmodule

// File: tb/tb_bus_arbiter.sv
module tb_bus_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int N    = 4;
  localparam int LIM  = 5;
  localparam int IDW  = $clog2(N);
  localparam int WAIT_BOUND = N * (LIM + 1) + 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   peer_req = '0;
  logic           lock = 1'b0, host_req = 1'b0, host_backoff = 1'b0;
  logic [N-1:0]   peer_grant;
  logic           host_grant;
  logic [IDW-1:0] owner_id;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  int m_own, m_last, m_cnt;
  bit m_host;
  int waitc [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_arbiter #(.N_PEERS(N), .FAIR_LIMIT(LIM)) dut (
    .clk(clk), .rst_n(rst_n), .peer_req(peer_req), .lock(lock),
    .host_req(host_req), .host_backoff(host_backoff),
    .peer_grant(peer_grant), .host_grant(host_grant), .owner_id(owner_id)
  );

  function automatic int pick(input logic [N-1:0] r, input int last);
    for (int k = 1; k <= N; k++) begin
      int p;
      p = (last + k) % N;
      if (r[p]) return p;
    end
    return -1;
  endfunction

  function automatic logic [N-1:0] exp_vec(input int own);
    logic [N-1:0] v;
    v = '0;
    if (own >= 0) v[own] = 1'b1;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // model step at a clock edge, using the inputs that were stable at that edge
  task automatic step();
    if (m_host) begin
      if (!host_req) m_host = 0;
    end else if (m_own >= 0) begin
      bit others, rel;
      others = ((peer_req & ~exp_vec(m_own)) != '0) || host_req;
      rel = !peer_req[m_own] || host_backoff || (m_cnt == LIM-1 && !lock && others);
      if (rel) begin
        m_last = m_own;
        m_own  = -1;
      end else if (m_cnt < LIM-1) m_cnt++;
    end else if (host_req) begin
      m_host = 1;
    end else begin
      int p;
      p = pick(peer_req, m_last);
      if (p >= 0) begin
        m_own = p;
        m_cnt = 0;
      end
    end
  endtask

  task automatic compare(input string tag);
    check(peer_grant == exp_vec(m_own), tag, peer_grant, exp_vec(m_own));
    check(host_grant == m_host, "R8", host_grant, m_host);
    check($countones({host_grant, peer_grant}) <= 1, "R2", {host_grant, peer_grant}, 0);
    check(owner_id == IDW'((m_own >= 0) ? m_own : 0), "R9", owner_id, (m_own >= 0) ? m_own : 0);
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    step();
    @(negedge clk);
    compare(tag);
    for (int i = 0; i < N; i++) begin
      if (peer_req[i] && !peer_grant[i] && !host_req && !host_grant && !lock) waitc[i]++;
      else waitc[i] = 0;
      if (waitc[i] > WAIT_BOUND) begin
        check(1'b0, "R5", waitc[i], WAIT_BOUND);
        waitc[i] = 0;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_abcd));
    m_own = -1; m_last = N-1; m_cnt = 0; m_host = 0;
    for (int i = 0; i < N; i++) waitc[i] = 0;
    peer_req = '1;
    host_req = 1'b1;
    repeat (3) @(negedge clk);
    // R1: no grants while reset is held
    check(peer_grant == '0 && !host_grant && owner_id == '0, "R1", {host_grant, peer_grant}, 0);
    peer_req = '0; host_req = 1'b0;
    rst_n = 1'b1;
    cyc("R1");
    check(peer_grant == '0, "R1", peer_grant, 0);

    // R3: all peers request, peer 0 wins first after reset
    peer_req = '1;
    cyc("R3");
    check(peer_grant == 4'b0001, "R3", peer_grant, 4'b0001);
    // R4: owner drops request, idle cycle, then peer 1
    peer_req[0] = 1'b0;
    cyc("R4");
    check(peer_grant == '0, "R4", peer_grant, 0);
    cyc("R3");
    check(peer_grant == 4'b0010, "R3", peer_grant, 4'b0010);

    // R5: contention, no lock: peer 1 forced off after LIM cycles
    for (int i = 0; i < LIM - 1; i++) cyc("R5");
    check(peer_grant == 4'b0010, "R5", peer_grant, 4'b0010);
    cyc("R5");
    check(peer_grant == '0, "R5", peer_grant, 0);
    cyc("R5");
    check(peer_grant == 4'b0100, "R5", peer_grant, 4'b0100);

    // R6: lock keeps peer 2 well past the limit
    lock = 1'b1;
    for (int i = 0; i < 3 * LIM; i++) cyc("R6");
    check(peer_grant == 4'b0100, "R6", peer_grant, 4'b0100);

    // R7: backoff overrides lock
    host_req = 1'b1; host_backoff = 1'b1;
    cyc("R7");
    check(peer_grant == '0, "R7", peer_grant, 0);
    host_backoff = 1'b0;
    cyc("R7");
    check(host_grant == 1'b1, "R7", host_grant, 1);

    // R8: host holds through backoff, lock and peer requests
    for (int i = 0; i < 12; i++) begin
      host_backoff = i[0];
      cyc("R8");
    end
    check(host_grant == 1'b1, "R8", host_grant, 1);
    host_req = 1'b0; host_backoff = 1'b0; lock = 1'b0;
    cyc("R8");
    check(host_grant == 1'b0, "R8", host_grant, 0);
    // rotation resumes after last peer owner (2): peer 3 next
    cyc("R3");
    check(peer_grant == 4'b1000, "R3", peer_grant, 4'b1000);

    // mixed random traffic
    for (int t = 0; t < 4000; t++) begin
      for (int i = 0; i < N; i++)
        if ($urandom % 6 == 0) peer_req[i] = ~peer_req[i];
      lock = ($urandom % 8 == 0);
      if ($urandom % 25 == 0) host_req = ~host_req;
      host_backoff = host_req && ($urandom % 4 == 0);
      cyc("R4");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule